// File: doc/BRIEF.md
# Carry-Save Inner-Product Accumulator

This block computes the inner product of two vectors of signed integers, one 8-bit element and one 16-bit element per clock, and delivers the 24-bit total. Each product is generated as an array of shifted partial products. These rows are folded into a running total that is held as two vectors, sum and carry, through a chain of 3:2 compressors. No carry propagates while a vector streams in. When the element marked last has been taken, the bank holding that total resolves it serially. Each clock it settles one bit position, from the least significant upward, over 24 clocks. It then presents the result with a one-cycle strobe and the number of the bank that produced it.

Two identical accumulator banks take turns. While one bank resolves its total, the input is steered to the other bank, so the next vector can stream in at once. If the input is steered to a bank that is still resolving, the block holds off the source by dropping its ready output. Arithmetic wraps modulo 2^24. The most negative weight of the 8-bit operand is handled by inverting its partial-product row and adding a correction one at the carry vector's least significant position. No overflow indication exists.

Top module: `pa_prod_acc`

## Requirements
- R1: After synchronous reset, `res_valid` is 0 and `in_ready` is 1. The first vector is steered to bank 0.
- R2: For a vector of signed pairs (a_i, b_i), `res_data` equals Σ a_i·b_i taken modulo 2^24. It holds for every a value from -128 to 127 and for the extreme b values -32768 and 32767.
- R3: A pair is taken on each rising edge where `in_valid` and `in_ready` are both 1. While the steered bank is not resolving, `in_ready` stays 1.
- R4: If the pair flagged by `in_last` is taken at edge k, then `res_valid` is 1 during exactly the one cycle that follows edge k+24. An N-element vector therefore completes N+24 clocks after its first pair.
- R5: Vectors go to banks 0, 1, 0, 1, … in the order their last pairs are taken. `res_bank` gives the bank of the reported result (0 or 1), and results appear in that same order.
- R6: While the steered bank is resolving, `in_ready` is 0. Operand values and flags presented in those cycles have no effect on any result.
- R7: For vectors back to back with N ≥ 24, no stall cycle occurs. For three back-to-back vectors with N < 24, the third vector stalls for exactly 24−N cycles.
- R8: Single-element vectors issued on consecutive clocks give results on consecutive cycles, with alternating `res_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| in_last | input | 1 | Pair is the final element of its vector |
| in_a | input | 8 | Signed 8-bit operand |
| in_b | input | 16 | Signed 16-bit operand |
| in_ready | output | 1 | Pair will be taken at the next edge if valid |
| res_valid | output | 1 | One-cycle strobe: result available |
| res_data | output | 24 | Inner product modulo 2^24 |
| res_bank | output | 1 | Bank that produced the result |

## Verification
The hardest case to reach is a stall in which the input is steered back to a bank that is still resolving. This happens only when two short vectors follow each other with no gap. The bench sends runs of back-to-back four-element vectors to cause this. During each stall cycle it drives junk operands flagged as last, and it measures the exact stall length. It also runs single-element vectors on consecutive clocks, so that both banks resolve with their finishes one cycle apart. A sweep over all 256 values of the 8-bit operand, plus the extreme 16-bit values, exercises the sign correction of the top partial-product row.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int A_W      = 8;
    localparam int B_W      = 16;
    localparam int ACC_W    = A_W + B_W;
    localparam int N_BANK   = 2;
    localparam int CNT_W    = $clog2(ACC_W);

    typedef logic [ACC_W-1:0] word_t;
    typedef logic [A_W-1:0][ACC_W-1:0] row_arr_t;

    typedef struct packed {
        word_t s;
        word_t c;
    } cs_t;

    typedef enum logic {BK_OPEN, BK_DRAIN} bank_st_e;

    // one 3:2 compression level; carries move up one position
    function automatic cs_t csa3(word_t x, word_t y, word_t z);
        cs_t r;
        r.s = x ^ y ^ z;
        r.c = ((x & y) | (x & z) | (y & z)) << 1;
        return r;
    endfunction
endpackage

// File: rtl/pa_pprod.sv
module pa_pprod
    import pa_pkg::*;
(
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output row_arr_t       rows_o,
    output logic           inject_o
);
    word_t b_ext;
    assign b_ext = {{(ACC_W-B_W){b_i[B_W-1]}}, b_i};

    generate
        for (genvar i = 0; i < A_W; i++) begin : g_row
            if (i == A_W-1) begin : g_neg
                // top bit carries negative weight: invert now, +1 injected later
                assign rows_o[i] = a_i[i] ? ~(b_ext << i) : '0;
            end else begin : g_pos
                assign rows_o[i] = a_i[i] ? (b_ext << i) : '0;
            end
        end
    endgenerate

    assign inject_o = a_i[A_W-1];
endmodule

// File: rtl/pa_bank.sv
module pa_bank
    import pa_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     add_en_i,
    input  logic     last_i,
    input  row_arr_t rows_i,
    input  logic     inject_i,
    output logic     busy_o,
    output logic     done_o,
    output word_t    result_o
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ACC_W-1);

    bank_st_e            st_q;
    cs_t                 acc_q;
    logic [ACC_W-2:0]    res_sh_q;
    logic                cy_q;
    logic [CNT_W-1:0]    cnt_q;

    cs_t fold [A_W+1];
    assign fold[0] = '{s: acc_q.s, c: acc_q.c | word_t'(inject_i)};

    generate
        for (genvar i = 0; i < A_W; i++) begin : g_fold
            assign fold[i+1] = csa3(fold[i].s, fold[i].c, rows_i[i]);
        end
    endgenerate

    logic bit_d, cy_d;
    assign bit_d = acc_q.s[0] ^ acc_q.c[0] ^ cy_q;
    assign cy_d  = (acc_q.s[0] & acc_q.c[0]) | (acc_q.s[0] & cy_q) | (acc_q.c[0] & cy_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= BK_OPEN;
            acc_q    <= '0;
            res_sh_q <= '0;
            cy_q     <= 1'b0;
            cnt_q    <= '0;
        end else begin
            case (st_q)
                BK_OPEN: begin
                    if (add_en_i) begin
                        acc_q <= fold[A_W];
                        if (last_i) begin
                            st_q  <= BK_DRAIN;
                            cnt_q <= '0;
                            cy_q  <= 1'b0;
                        end
                    end
                end
                default: begin
                    acc_q.s  <= acc_q.s >> 1;
                    acc_q.c  <= acc_q.c >> 1;
                    cy_q     <= cy_d;
                    res_sh_q <= {bit_d, res_sh_q[ACC_W-2:1]};
                    cnt_q    <= cnt_q + 1'b1;
                    if (cnt_q == LAST_CNT) st_q <= BK_OPEN;
                end
            endcase
        end
    end

    assign busy_o   = (st_q == BK_DRAIN);
    assign done_o   = busy_o && (cnt_q == LAST_CNT);
    assign result_o = {bit_d, res_sh_q};

    // R6: a resolving bank is never written by the input steering
    p_no_add_drain_r6: assert property (@(posedge clk) disable iff (rst)
        add_en_i |-> (st_q == BK_OPEN));
    // R2: the correction one relies on a free carry LSB while accumulating
    p_carry_lsb_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == BK_OPEN) |-> (acc_q.c[0] == 1'b0));
    // R2: after the last resolved bit both vectors have shifted out to zero
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (acc_q.s == '0 && acc_q.c == '0 && !busy_o));
endmodule

// File: rtl/pa_prod_acc.sv
module pa_prod_acc
    import pa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [A_W-1:0]   in_a,
    input  logic [B_W-1:0]   in_b,
    output logic             in_ready,
    output logic             res_valid,
    output logic [ACC_W-1:0] res_data,
    output logic             res_bank
);
    logic                sel_q;
    logic [N_BANK-1:0]   busy, done;
    word_t               res_w [N_BANK];
    row_arr_t            rows;
    logic                inject;
    logic                accept;

    pa_pprod u_pprod (
        .a_i      (in_a),
        .b_i      (in_b),
        .rows_o   (rows),
        .inject_o (inject)
    );

    assign in_ready = !busy[sel_q];
    assign accept   = in_valid && in_ready;

    generate
        for (genvar g = 0; g < N_BANK; g++) begin : g_bank
            pa_bank u_bank (
                .clk      (clk),
                .rst      (rst),
                .add_en_i (accept && (sel_q == 1'(g))),
                .last_i   (in_last),
                .rows_i   (rows),
                .inject_i (inject),
                .busy_o   (busy[g]),
                .done_o   (done[g]),
                .result_o (res_w[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= 1'b0;
            res_valid <= 1'b0;
            res_data  <= '0;
            res_bank  <= 1'b0;
        end else begin
            if (accept && in_last) sel_q <= ~sel_q;
            res_valid <= |done;
            res_data  <= done[1] ? res_w[1] : res_w[0];
            res_bank  <= done[1];
        end
    end

    logic seen_q, prev_bank_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q      <= 1'b0;
            prev_bank_q <= 1'b0;
        end else if (res_valid) begin
            seen_q      <= 1'b1;
            prev_bank_q <= res_bank;
        end
    end

    // R4: the two banks never finish on the same edge
    p_one_done_r4: assert property (@(posedge clk) disable iff (rst)
        !(done[0] && done[1]));
    // R5: consecutive results come from alternating banks
    p_alt_bank_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && seen_q) |-> (res_bank != prev_bank_q));
    // R5: the first result after reset comes from bank 0
    p_first_bank_r5: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !seen_q) |-> (res_bank == 1'b0));
    // R6: a refused last flag does not move the steering
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready && in_last) |=> $stable(sel_q));
endmodule

// File: tb/pa_prod_acc_tb.sv
module pa_prod_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_last = 1'b0;
    logic [7:0]  in_a = '0;
    logic [15:0] in_b = '0;
    logic        in_ready, res_valid, res_bank;
    logic [23:0] res_data;

    always #2.5 clk = ~clk;

    pa_prod_acc dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
        .in_a(in_a), .in_b(in_b), .in_ready(in_ready),
        .res_valid(res_valid), .res_data(res_data), .res_bank(res_bank)
    );

    int errors = 0, checks = 0;
    int cyc = 0;
    int stalls = 0;
    bit done_flag = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // expectation list
    logic [23:0] exp_data [1024];
    bit          exp_bank [1024];
    int          exp_cyc  [1024];
    int          head = 0, tail = 0;
    longint      acc = 0;
    bit          nxt_bank = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one pair; junk is shown during stall cycles (R6)
    task automatic push(input logic signed [7:0] a, input logic signed [15:0] b, input bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_a = 8'h5A; in_b = 16'hBEEF; in_last = 1'b1;
        #1;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
            in_a = in_a + 8'd37; in_b = in_b ^ 16'h3C3C;
            #1;
        end
        in_a = a; in_b = b; in_last = last;
        acc += longint'(a) * longint'(b);
        if (last) begin
            exp_data[tail] = acc[23:0];
            exp_bank[tail] = nxt_bank;
            exp_cyc[tail]  = cyc + 1 + 24;
            tail++;
            nxt_bank = ~nxt_bank;
            acc = 0;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain_wait();
        int guard = 0;
        while (head != tail && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(head == tail, "R4 all results arrived", head, tail);
    endtask

    // monitor: R2 value, R4 timing, R5 bank
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (head == tail) begin
                chk(1'b0, "R4 unexpected result", res_data, 0);
            end else begin
                chk(res_data == exp_data[head], "R2 result value", res_data, exp_data[head]);
                chk(res_bank == exp_bank[head], "R5 result bank", res_bank, exp_bank[head]);
                chk(cyc == exp_cyc[head], "R4 result cycle", cyc, exp_cyc[head]);
                head++;
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5 * 150000);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1
        chk(res_valid == 1'b0, "R1 res_valid after reset", res_valid, 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

        // R2: every a value, four per vector, with gaps
        for (int v = 0; v < 64; v++) begin
            for (int e = 0; e < 4; e++) begin
                logic signed [7:0]  av;
                logic signed [15:0] bv;
                av = 8'(v * 4 + e - 128);
                case (e)
                    0: bv = 16'sh8000;
                    1: bv = 16'sh7FFF;
                    2: bv = 16'(v * 1031 - 20000);
                    default: bv = -16'sd1;
                endcase
                push(av, bv, e == 3);
            end
            if (v % 8 == 7) idle(2);
        end
        idle(1);
        drain_wait();

        // R2: extreme single products and a long saturating-wrap vector
        push(-8'sd128, -16'sh8000, 1'b1);
        push(8'sd127, 16'sh7FFF, 1'b1);
        for (int e = 0; e < 40; e++) push(-8'sd128, -16'sh8000, e == 39);
        idle(1);
        drain_wait();

        // R7: N = 30 back to back, no stall (R3)
        stalls = 0;
        for (int v = 0; v < 3; v++)
            for (int e = 0; e < 30; e++)
                push(8'(e * 7 - v), 16'(e * 999 + v * 17), e == 29);
        chk(stalls == 0, "R3 R7 no stall for N>=24", stalls, 0);
        idle(1);
        drain_wait();

        // R6 R7: N = 4 back to back, third vector stalls 20 cycles
        stalls = 0;
        for (int v = 0; v < 3; v++)
            for (int e = 0; e < 4; e++)
                push(8'(e * 33 + v - 60), 16'(e * 4321 - v * 77), e == 3);
        chk(stalls == 20, "R6 R7 stall length for N=4", stalls, 20);
        idle(1);
        drain_wait();

        // R8: single-element vectors on consecutive clocks
        for (int v = 0; v < 6; v++) push(8'(v * 41 - 100), 16'(v * 12345), 1'b1);
        idle(1);
        drain_wait();

        idle(2);
        chk(res_valid == 1'b0, "R4 strobe cleared when idle", res_valid, 0);
        finish_run();
    end
endmodule